// File: doc/BRIEF.md
# Ethernet Power-Down and Wake Event Register

This block holds the power-management control and status word of an Ethernet MAC and drives the receive-side frame gating that follows from it. Software accesses the word over a simple register bus at one fixed offset. While the power-down bit is set, the block asks the receive path to drop every frame. External pattern detectors report a recognised magic packet, a recognised wake-up frame, or a unicast frame that passed address filtering, each as a single-cycle pulse.

An enabled wake event that arrives while powered down does four things. It clears power-down, so later frames are forwarded again. It records which kind of event occurred in one of two sticky flags. It emits a one-cycle power-management event pulse. It raises the interrupt-status output. Reading the word clears the flags, and the interrupt output falls once both flags are clear. A separate write-one strobe bit resets the wake-up filter pointer held by the external matcher.

Top module: `pm_wake_ctl`

## Requirements
- R1: After reset every stored field is 0, `drop_frames`, `pm_event`, `filt_ptr_rst` and `pmt_irq` are low, and a read of the word returns 0.
- R2: `drop_frames` equals the power-down bit (bit 0) in the same cycle, and a register write with bit 0 set and an enable bit set makes it high from the next cycle.
- R3: A qualified wake event while powered down clears power-down on the next clock edge, and `pm_event` is high for exactly the one cycle after the event.
- R4: Bit 1 enables magic-packet events and bit 2 enables wake-up-frame events. When bit 9 is set, a `ucast_hit` pulse counts as a wake-up frame. A detector pulse whose enable is clear has no effect.
- R5: Bit 5 is set by a magic-packet event and bit 6 by a wake-up-frame event. A read at the register offset returns them and clears both on that clock edge.
- R6: `pmt_irq` is high while bit 5 or bit 6 is set, and it stays high until a read leaves both clear.
- R7: A write whose bit 0 is 1 while bits 1 and 2 are both 0 is ignored as a whole. No field changes and no strobe fires.
- R8: Writing 1 to bit 31 makes `filt_ptr_rst` high for exactly the one cycle after the write. Bit 31 always reads as 0.
- R9: A wake event in the same cycle as a read at the offset still sets its flag after that read.
- R10: Detector pulses while the power-down bit is clear set no flag, raise no `pmt_irq` and produce no `pm_event`.
- R11: Unused bit positions read as 0. Accesses at any other address change no state. `bus_rdata` is 0 whenever no read at the offset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational during a read |
| magic_hit | input | 1 | Pulse: magic packet recognised |
| wake_hit | input | 1 | Pulse: wake-up frame pattern matched |
| ucast_hit | input | 1 | Pulse: unicast frame passed address filtering |
| drop_frames | output | 1 | Receive path drops frames while high |
| pm_event | output | 1 | One-cycle power-management event |
| filt_ptr_rst | output | 1 | One-cycle wake-up filter pointer reset |
| pmt_irq | output | 1 | Power-management interrupt status |

## Verification
Three kinds of internal fault are visible at the ports. A wrong power-down state shows on `drop_frames` in the very cycle it occurs. A missed or spurious event shows on `pm_event` and `pmt_irq` one clock after the detector pulse. A flag that is wrongly kept or lost shows in the next read of the word and in `pmt_irq` one clock after that read. The bench sweeps every combination of the three stored enables against each of the three detector pulses and computes the expected word arithmetically. It then adds the cases where a read and an event coincide, a write that is refused, and accesses at a wrong offset.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
   localparam int BIT_PD   = 0;
   localparam int BIT_MPE  = 1;
   localparam int BIT_WFE  = 2;
   localparam int BIT_MPR  = 5;
   localparam int BIT_WFR  = 6;
   localparam int BIT_GU   = 9;
   localparam int BIT_PRST = 31;
   localparam int MIN_DW   = BIT_PRST + 1;

   typedef struct packed {
      logic gu;
      logic wf_en;
      logic mp_en;
      logic pd;
   } pm_ctrl_t;

   typedef struct packed {
      logic wfr;
      logic mpr;
   } pm_flags_t;
endpackage

// File: rtl/pm_evt_qual.sv
module pm_evt_qual
   import pm_wake_pkg::*;
(
   input  pm_ctrl_t ctrl,
   input  logic     magic_hit,
   input  logic     wake_hit,
   input  logic     ucast_hit,
   output logic     mp_evt,
   output logic     wf_evt
);
   logic wake_src;

   assign wake_src = wake_hit | (ctrl.gu & ucast_hit);
   assign mp_evt   = ctrl.pd & ctrl.mp_en & magic_hit;
   assign wf_evt   = ctrl.pd & ctrl.wf_en & wake_src;
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
   import pm_wake_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit UCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wake_any,
   output pm_ctrl_t          ctrl,
   output logic              ptr_rst
);
   logic pd_q, mpe_q, wfe_q, gu_q;
   logic wr_ok;

   // A power-down request needs one of the enables in the same word
   assign wr_ok = wr_sel & (~wdata[BIT_PD] | wdata[BIT_MPE] | wdata[BIT_WFE]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pd_q    <= 1'b0;
         mpe_q   <= 1'b0;
         wfe_q   <= 1'b0;
         ptr_rst <= 1'b0;
      end else begin
         ptr_rst <= wr_ok & wdata[BIT_PRST];
         if (wr_ok) begin
            mpe_q <= wdata[BIT_MPE];
            wfe_q <= wdata[BIT_WFE];
            pd_q  <= wdata[BIT_PD];
         end
         if (wake_any) pd_q <= 1'b0;  // wake has priority over a write
      end
   end

   if (UCAST_EN) begin : g_gu
      always_ff @(posedge clk) begin
         if (!rst_n)     gu_q <= 1'b0;
         else if (wr_ok) gu_q <= wdata[BIT_GU];
      end
   end else begin : g_no_gu
      assign gu_q = 1'b0;
   end

   assign ctrl = '{gu: gu_q, wf_en: wfe_q, mp_en: mpe_q, pd: pd_q};

   // R3: power-down is gone the cycle after a wake event
   a_r3_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wake_any |=> !pd_q);
   // R7: power-down never stands without an enable
   a_r7_pd_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |-> (mpe_q | wfe_q));
   // R8: pointer reset strobe is a single cycle
   a_r8_ptr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst |=> !ptr_rst);
endmodule

// File: rtl/pm_flag_bank.sv
module pm_flag_bank
   import pm_wake_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_sel,
   input  logic      mp_evt,
   input  logic      wf_evt,
   output pm_flags_t flags,
   output logic      pm_event,
   output logic      irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags    <= '0;
         pm_event <= 1'b0;
      end else begin
         // a new event outranks the clear-on-read
         flags.mpr <= mp_evt | (flags.mpr & ~rd_sel);
         flags.wfr <= wf_evt | (flags.wfr & ~rd_sel);
         pm_event  <= mp_evt | wf_evt;
      end
   end

   assign irq = flags.mpr | flags.wfr;

   // R6: interrupt holds until a read
   a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_sel) |=> irq);
   // R9: event during read is kept
   a_r9_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && mp_evt) |=> flags.mpr);
   // R5: a read without new events empties the flags
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && !mp_evt && !wf_evt) |=> !irq);
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
   import pm_wake_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int REG_OFFSET = 'h2C,
   parameter bit UCAST_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              magic_hit,
   input  logic              wake_hit,
   input  logic              ucast_hit,
   output logic              drop_frames,
   output logic              pm_event,
   output logic              filt_ptr_rst,
   output logic              pmt_irq
);
   localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

   if (DATA_W < MIN_DW) begin : g_bad_dw
      initial $fatal(1, "pm_wake_ctl: DATA_W must be at least %0d", MIN_DW);
   end
   if (REG_OFFSET < 0 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_off
      initial $fatal(1, "pm_wake_ctl: REG_OFFSET outside the address range");
   end

   logic      wr_sel, rd_sel, mp_evt, wf_evt;
   pm_ctrl_t  ctrl;
   pm_flags_t flags;

   assign wr_sel = bus_wr & (bus_addr == OFFS);
   assign rd_sel = bus_rd & (bus_addr == OFFS);

   pm_evt_qual u_qual (
      .ctrl      (ctrl),
      .magic_hit (magic_hit),
      .wake_hit  (wake_hit),
      .ucast_hit (ucast_hit),
      .mp_evt    (mp_evt),
      .wf_evt    (wf_evt)
   );

   pm_ctrl_regs #(.DATA_W(DATA_W), .UCAST_EN(UCAST_EN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_sel),
      .wdata    (bus_wdata),
      .wake_any (mp_evt | wf_evt),
      .ctrl     (ctrl),
      .ptr_rst  (filt_ptr_rst)
   );

   pm_flag_bank u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sel   (rd_sel),
      .mp_evt   (mp_evt),
      .wf_evt   (wf_evt),
      .flags    (flags),
      .pm_event (pm_event),
      .irq      (pmt_irq)
   );

   assign drop_frames = ctrl.pd;

   always_comb begin
      bus_rdata = '0;
      if (rd_sel) begin
         bus_rdata[BIT_PD]  = ctrl.pd;
         bus_rdata[BIT_MPE] = ctrl.mp_en;
         bus_rdata[BIT_WFE] = ctrl.wf_en;
         bus_rdata[BIT_MPR] = flags.mpr;
         bus_rdata[BIT_WFR] = flags.wfr;
         bus_rdata[BIT_GU]  = ctrl.gu;
      end
   end

   // R10: no event is produced while awake
   a_r10_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_frames |=> !pm_event);
   // R11: read data is silent outside a read at the offset
   a_r11_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_sel |-> (bus_rdata == '0));
endmodule

// File: tb/pm_wake_ctl_tb.sv
`timescale 1ns/1ps
module pm_wake_ctl_tb;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int OFF = 'h2C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic magic_hit = 1'b0, wake_hit = 1'b0, ucast_hit = 1'b0;
   logic drop_frames, pm_event, filt_ptr_rst, pmt_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pm_wake_ctl #(.ADDR_W(AW), .DATA_W(DW), .REG_OFFSET(OFF)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .magic_hit(magic_hit), .wake_hit(wake_hit), .ucast_hit(ucast_hit),
      .drop_frames(drop_frames), .pm_event(pm_event),
      .filt_ptr_rst(filt_ptr_rst), .pmt_irq(pmt_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      #1;
   endtask

   // drives a read, optionally with detector pulses in the same cycle
   task automatic bus_read(input logic [AW-1:0] a, input logic m, input logic w,
                           output logic [DW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a; magic_hit = m; wake_hit = w;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; magic_hit = 1'b0; wake_hit = 1'b0;
      #1;
   endtask

   task automatic pulse(input logic m, input logic w, input logic u);
      @(negedge clk);
      magic_hit = m; wake_hit = w; ucast_hit = u;
      @(negedge clk);
      magic_hit = 1'b0; wake_hit = 1'b0; ucast_hit = 1'b0;
      #1;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(drop_frames == 0 && pm_event == 0 && filt_ptr_rst == 0 && pmt_irq == 0,
          "R1 outputs", {drop_frames, pm_event, filt_ptr_rst, pmt_irq}, 0);
      bus_read(AW'(OFF), 0, 0, rd);
      chk(rd == 0, "R1 readback", rd, 0);
      chk(bus_rdata == 0, "R11 idle rdata", bus_rdata, 0);

      // sweep: enables x detector kind
      for (int cfg = 0; cfg < 8; cfg++) begin
         for (int ev = 0; ev < 3; ev++) begin
            logic mp, wf, gu, pd_exp, hit;
            logic [DW-1:0] base, exp;
            mp = cfg[0]; wf = cfg[1]; gu = cfg[2];
            base = (DW'(gu) << 9) | (DW'(wf) << 2) | (DW'(mp) << 1);
            bus_write(AW'(OFF), base | 1);
            pd_exp = mp | wf;
            chk(drop_frames == pd_exp, "R2/R7 power-down write", drop_frames, pd_exp);
            if (!pd_exp) begin
               bus_read(AW'(OFF), 0, 0, rd);
               chk(rd == 0, "R7 refused write", rd, 0);
            end
            hit = pd_exp && (ev == 0 ? mp : ev == 1 ? wf : (wf && gu));
            pulse(ev == 0, ev == 1, ev == 2);
            chk(pm_event == hit, "R3/R4/R10 pm_event", pm_event, hit);
            chk(drop_frames == (pd_exp && !hit), "R3 pd clear", drop_frames, pd_exp && !hit);
            chk(pmt_irq == hit, "R6 irq set", pmt_irq, hit);
            exp = (pd_exp ? base : 0) | DW'(pd_exp && !hit)
                  | (DW'(hit && ev == 0) << 5) | (DW'(hit && ev != 0) << 6);
            bus_read(AW'(OFF), 0, 0, rd);
            chk(rd == exp, "R4/R5 readback", rd, exp);
            chk(pmt_irq == 0, "R5/R6 irq after read", pmt_irq, 0);
            bus_read(AW'(OFF), 0, 0, rd);
            chk(rd == (exp & ~32'h60), "R5 flags cleared", rd, exp & ~32'h60);
            bus_write(AW'(OFF), 0);
         end
      end

      // R10: awake, enabled magic pulse ignored
      bus_write(AW'(OFF), 32'h2);
      pulse(1, 1, 0);
      chk(pm_event == 0 && pmt_irq == 0, "R10 awake pulse", {pm_event, pmt_irq}, 0);
      bus_read(AW'(OFF), 0, 0, rd);
      chk(rd == 32'h2, "R10 no flags", rd, 32'h2);

      // R6/R9: flag held across refused clear, event during read
      bus_write(AW'(OFF), 32'h7);
      pulse(1, 0, 0);
      bus_write(AW'(OFF), 32'h7);
      bus_read(AW'(OFF), 0, 1, rd);
      chk(rd == 32'h27, "R9 read during event", rd, 32'h27);
      chk(pmt_irq == 1, "R6 irq held by new flag", pmt_irq, 1);
      bus_read(AW'(OFF), 0, 0, rd);
      chk(rd == 32'h46, "R9 wake flag kept", rd, 32'h46);
      chk(pmt_irq == 0, "R6 irq cleared", pmt_irq, 0);

      // R8: pointer reset strobe
      bus_write(AW'(OFF), 32'h8000_0000);
      chk(filt_ptr_rst == 1, "R8 strobe high", filt_ptr_rst, 1);
      @(negedge clk); #1;
      chk(filt_ptr_rst == 0, "R8 strobe single", filt_ptr_rst, 0);

      // R11: reserved bits and other offsets
      bus_write(AW'(OFF), 32'hFFFF_FFFF);
      @(negedge clk); #1;
      bus_read(AW'(OFF), 0, 0, rd);
      chk(rd == 32'h207, "R11 reserved zero, R8 bit31 reads 0", rd, 32'h207);
      bus_write(AW'(OFF), 0);
      bus_write(AW'(OFF + 4), 32'h207);
      chk(drop_frames == 0, "R11 foreign write", drop_frames, 0);
      bus_read(AW'(OFF + 4), 0, 0, rd);
      chk(rd == 0, "R11 foreign read", rd, 0);
      bus_read(AW'(OFF), 0, 0, rd);
      chk(rd == 0, "R11 state untouched", rd, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule